// File: doc/BRIEF.md
# Secondary Interrupt Hub with Direct Routing

This block gathers 32 level-sensitive interrupt request lines from peripherals. The enabled and active requests are combined into a single summary line, output bit 31, which feeds an upstream interrupt controller. Software enables sources one at a time through set and clear registers, so it never has to do a read-modify-write.

A band of inputs, 21 through 30, can also be sent straight to output lines with the same index. Those lines then skip the combining stage and can reach the upstream controller as separate requests.

Software reaches the block over a plain 32-bit register port with a 4 KB byte window. Each register is selected by a word index, which is the byte address shifted right by two. Reads are combinational from the stored state. Writes take effect at the clock edge on which the write strobe is sampled.

Top module: `sic_irq_hub`

## Requirements
- R1: The raw level register captures `src_i` on every clock edge. Reading word index 1 returns it.
- R2: Reading word index 0 returns the raw level ANDed with the enable mask.
- R3: Reading word index 2 returns the enable mask. A write to word 2 ORs the write data into the mask. A write to word 3 clears every mask bit that is set in the write data.
- R4: Reading word index 4 returns only bit 0 of the raw level; bits 31:1 read as zero. A nonzero write to word 4 sets mask bit 0. A nonzero write to word 5 clears mask bit 0. A zero write to either word changes nothing.
- R5: Reading word index 8 returns the routing-enable register. A write to word 8 ORs in the write data ANDed with 0x7FE00000, so only bits 21..30 can become set. A write to word 9 clears the routing bits that are set in the write data.
- R6: For each line i from 21 to 30, output i equals raw level bit i while routing bit i is set. Output i is low while routing bit i is clear.
- R7: Output bit 31 is high exactly when the raw level ANDed with the enable mask is nonzero.
- R8: Output bits 0..20 are always low.
- R9: A read of any other word index in the window returns zero. A write to any other word index changes no state. This includes word 5 on read and indices at or above 10.
- R10: While `rst_n` is low, the raw level, enable mask and routing register are zero and all outputs are low. Reset asserts asynchronously.
- R11: Outputs are registered. They show the effect of an input change or a register write after the same clock edge that updates the stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Level interrupt requests |
| bus_addr | input | 12 | Byte address inside the register window |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_o | output | 32 | Output request lines; bit 31 is the summary |

## Verification
The assertions check the following on every cycle:
- the summary line against the stored raw level and mask;
- each routed line against its routing bit and raw bit;
- that lines 0..20 stay low;
- that routing bits outside 21..30 stay clear;
- the effect of set and clear writes one cycle later.

Some behaviours can only be shown by the bench's scenarios. These are:
- the read-back values of each word index, including zero for unmapped and write-only indices;
- that a zero write to the single-bit words changes nothing;
- that the upper address bits are decoded;
- that an asynchronous reset in the middle of a run wipes the state.

// File: rtl/sic_pkg.sv
package sic_pkg;
  // Word indices (byte offset >> 2); the numbering is what software decodes.
  localparam int SIC_W_STATUS  = 0;
  localparam int SIC_W_RAW     = 1;
  localparam int SIC_W_EN      = 2;  // read mask, write sets
  localparam int SIC_W_ENCLR   = 3;
  localparam int SIC_W_SOFT    = 4;  // read raw bit 0, nonzero write sets mask bit 0
  localparam int SIC_W_SOFTCLR = 5;
  localparam int SIC_W_ROUTE   = 8;  // read routing, write sets
  localparam int SIC_W_ROUTECLR = 9;
endpackage

// File: rtl/sic_regfile.sv
module sic_regfile #(
  parameter int N     = 32,
  parameter int WW    = 10,
  parameter int PT_LO = 21,
  parameter int PT_HI = 30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  src_i,
  input  logic          we,
  input  logic [WW-1:0] word,
  input  logic [N-1:0]  wdata,
  output logic [N-1:0]  raw_d,
  output logic [N-1:0]  mask_d,
  output logic [N-1:0]  route_d,
  output logic [N-1:0]  raw_q,
  output logic [N-1:0]  mask_q,
  output logic [N-1:0]  route_q
);
  localparam logic [WW-1:0] WI_EN      = WW'(sic_pkg::SIC_W_EN);
  localparam logic [WW-1:0] WI_ENCLR   = WW'(sic_pkg::SIC_W_ENCLR);
  localparam logic [WW-1:0] WI_SOFT    = WW'(sic_pkg::SIC_W_SOFT);
  localparam logic [WW-1:0] WI_SOFTCLR = WW'(sic_pkg::SIC_W_SOFTCLR);
  localparam logic [WW-1:0] WI_RT      = WW'(sic_pkg::SIC_W_ROUTE);
  localparam logic [WW-1:0] WI_RTCLR   = WW'(sic_pkg::SIC_W_ROUTECLR);

  function automatic logic [N-1:0] band_mask();
    logic [N-1:0] m;
    for (int i = 0; i < N; i++) m[i] = (i >= PT_LO) && (i <= PT_HI);
    return m;
  endfunction
  localparam logic [N-1:0] RT_BAND = band_mask();

  logic mask_en, route_en;
  logic wnz;

  assign wnz = |wdata;

  always_comb begin
    raw_d    = src_i;
    mask_d   = mask_q;
    route_d  = route_q;
    mask_en  = 1'b0;
    route_en = 1'b0;
    if (we) begin
      unique case (word)
        WI_EN:      begin mask_d = mask_q | wdata;  mask_en = 1'b1; end
        WI_ENCLR:   begin mask_d = mask_q & ~wdata; mask_en = 1'b1; end
        WI_SOFT:    begin mask_d[0] = mask_q[0] | wnz;  mask_en = wnz; end
        WI_SOFTCLR: begin mask_d[0] = mask_q[0] & ~wnz; mask_en = wnz; end
        WI_RT:      begin route_d = route_q | (wdata & RT_BAND); route_en = 1'b1; end
        WI_RTCLR:   begin route_d = route_q & ~wdata;            route_en = 1'b1; end
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q   <= '0;
      mask_q  <= '0;
      route_q <= '0;
    end else begin
      raw_q <= raw_d;
      if (mask_en)  mask_q  <= mask_d;
      if (route_en) route_q <= route_d;
    end
  end
endmodule

// File: rtl/sic_route.sv
module sic_route #(
  parameter int N     = 32,
  parameter int PT_LO = 21,
  parameter int PT_HI = 30,
  parameter int MERGE = 31
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw_d,
  input  logic [N-1:0] mask_d,
  input  logic [N-1:0] route_d,
  output logic [N-1:0] irq_q
);
  logic [N-1:0] irq_d;

  for (genvar i = 0; i < N; i++) begin : g_line
    if (i == MERGE) begin : g_merge
      assign irq_d[i] = |(raw_d & mask_d);
    end else if (i >= PT_LO && i <= PT_HI) begin : g_direct
      assign irq_d[i] = route_d[i] & raw_d[i];
    end else begin : g_idle
      assign irq_d[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_d;
  end
endmodule

// File: rtl/sic_rdmux.sv
module sic_rdmux #(
  parameter int N  = 32,
  parameter int WW = 10
) (
  input  logic [WW-1:0] word,
  input  logic [N-1:0]  raw_q,
  input  logic [N-1:0]  mask_q,
  input  logic [N-1:0]  route_q,
  output logic [N-1:0]  rdata
);
  localparam logic [WW-1:0] WI_STATUS = WW'(sic_pkg::SIC_W_STATUS);
  localparam logic [WW-1:0] WI_RAW    = WW'(sic_pkg::SIC_W_RAW);
  localparam logic [WW-1:0] WI_EN     = WW'(sic_pkg::SIC_W_EN);
  localparam logic [WW-1:0] WI_SOFT   = WW'(sic_pkg::SIC_W_SOFT);
  localparam logic [WW-1:0] WI_RT     = WW'(sic_pkg::SIC_W_ROUTE);

  always_comb begin
    rdata = '0;
    unique case (word)
      WI_STATUS: rdata = raw_q & mask_q;
      WI_RAW:    rdata = raw_q;
      WI_EN:     rdata = mask_q;
      WI_SOFT:   rdata[0] = raw_q[0];
      WI_RT:     rdata = route_q;
      default:   ;
    endcase
  end
endmodule

// File: rtl/sic_irq_hub.sv
module sic_irq_hub #(
  parameter int N     = 32,
  parameter int AW    = 12,
  parameter int PT_LO = 21,
  parameter int PT_HI = 30,
  parameter int MERGE = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  src_i,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [N-1:0]  bus_wdata,
  output logic [N-1:0]  bus_rdata,
  output logic [N-1:0]  irq_o
);
  localparam int WW = AW - 2;

  logic [WW-1:0] word;
  logic [N-1:0]  raw_d, mask_d, route_d;
  logic [N-1:0]  raw_q, mask_q, route_q;
  logic          unused_lsb;

  assign word       = bus_addr[AW-1:2];
  assign unused_lsb = ^bus_addr[1:0];

  sic_regfile #(.N(N), .WW(WW), .PT_LO(PT_LO), .PT_HI(PT_HI)) u_regs (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .we(bus_we), .word(word),
    .wdata(bus_wdata), .raw_d(raw_d), .mask_d(mask_d), .route_d(route_d),
    .raw_q(raw_q), .mask_q(mask_q), .route_q(route_q)
  );

  sic_route #(.N(N), .PT_LO(PT_LO), .PT_HI(PT_HI), .MERGE(MERGE)) u_route (
    .clk(clk), .rst_n(rst_n), .raw_d(raw_d), .mask_d(mask_d),
    .route_d(route_d), .irq_q(irq_o)
  );

  sic_rdmux #(.N(N), .WW(WW)) u_rd (
    .word(word), .raw_q(raw_q), .mask_q(mask_q), .route_q(route_q),
    .rdata(bus_rdata)
  );
endmodule

// File: rtl/sic_irq_hub_chk.sv
module sic_irq_hub_chk #(
  parameter int N     = 32,
  parameter int AW    = 12,
  parameter int PT_LO = 21,
  parameter int PT_HI = 30,
  parameter int MERGE = 31
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  src_i,
  input logic [AW-1:0] bus_addr,
  input logic          bus_we,
  input logic [N-1:0]  bus_wdata,
  input logic [N-1:0]  irq_o,
  input logic [N-1:0]  raw_q,
  input logic [N-1:0]  mask_q,
  input logic [N-1:0]  route_q
);
  localparam int WW = AW - 2;
  logic [WW-1:0] w;
  assign w = bus_addr[AW-1:2];

  // R1: raw level is last cycle's input
  a_r1_raw_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> raw_q == $past(src_i));

  // R7: summary line tracks stored raw & mask
  a_r7_summary: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o[MERGE] == |(raw_q & mask_q));

  // R3: set write leaves every written bit enabled
  a_r3_enset: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && w == WW'(sic_pkg::SIC_W_EN)) |=> (mask_q & $past(bus_wdata)) == $past(bus_wdata));

  // R3: clear write leaves every written bit disabled
  a_r3_enclr: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && w == WW'(sic_pkg::SIC_W_ENCLR)) |=> (mask_q & $past(bus_wdata)) == '0);

  // R5: routing clear
  a_r5_rtclr: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && w == WW'(sic_pkg::SIC_W_ROUTECLR)) |=> (route_q & $past(bus_wdata)) == '0);

  for (genvar i = 0; i < N; i++) begin : g_chk
    if (i >= PT_LO && i <= PT_HI) begin : g_pt
      // R6: routed line equals raw bit gated by routing bit
      a_r6_direct: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o[i] == (raw_q[i] & route_q[i]));
    end else begin : g_np
      // R5: routing bits outside the band never set
      a_r5_band: assert property (@(posedge clk) disable iff (!rst_n) !route_q[i]);
      if (i != MERGE) begin : g_lo
        // R8: unused lines stay low
        a_r8_low: assert property (@(posedge clk) disable iff (!rst_n) !irq_o[i]);
      end
    end
  end
endmodule

bind sic_irq_hub sic_irq_hub_chk #(.N(N), .AW(AW), .PT_LO(PT_LO), .PT_HI(PT_HI), .MERGE(MERGE)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .irq_o(irq_o), .raw_q(raw_q), .mask_q(mask_q), .route_q(route_q)
);

// File: tb/sic_irq_hub_test.sv
module sic_irq_hub_test;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_i = '0;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, irq_o;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sic_irq_hub uut (.clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o));

  typedef struct packed {
    logic        we;
    logic [9:0]  word;
    logic [31:0] wdata;
    logic [31:0] src;
    logic [31:0] irq;
    logic [9:0]  rdw;
    logic [31:0] rd;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 10'd2,   32'h000000F0, 32'h00000010, 32'h80000000, 10'd0, 32'h00000010}, // R3 set, R2, R7
    '{1'b1, 10'd3,   32'h00000010, 32'h00000010, 32'h00000000, 10'd2, 32'h000000E0}, // R3 clear
    '{1'b0, 10'd0,   32'h0,        32'h00000020, 32'h80000000, 10'd1, 32'h00000020}, // R1, R11
    '{1'b1, 10'd8,   32'hFFFFFFFF, 32'h00000020, 32'h80000000, 10'd8, 32'h7FE00000}, // R5 band mask
    '{1'b0, 10'd0,   32'h0,        32'h00600020, 32'h80600000, 10'd0, 32'h00000020}, // R6 routed
    '{1'b1, 10'd9,   32'h00200000, 32'h00600020, 32'h80400000, 10'd8, 32'h7FC00000}, // R5 clear, R6 low
    '{1'b1, 10'd4,   32'h00000005, 32'h00000001, 32'h80000000, 10'd4, 32'h00000001}, // R4 set
    '{1'b1, 10'd5,   32'h00000100, 32'h00000001, 32'h00000000, 10'd2, 32'h000000E0}, // R4 clear
    '{1'b1, 10'd7,   32'hFFFFFFFF, 32'h00000001, 32'h00000000, 10'd7, 32'h00000000}, // R9
    '{1'b1, 10'd4,   32'h00000000, 32'h00000001, 32'h00000000, 10'd2, 32'h000000E0}, // R4 zero write
    '{1'b0, 10'd0,   32'h0,        32'h80000001, 32'h00000000, 10'd1, 32'h80000001}, // R1, R8
    '{1'b1, 10'd2,   32'h80000000, 32'h80000001, 32'h80000000, 10'd0, 32'h80000000}, // R2, R7
    '{1'b0, 10'd0,   32'h0,        32'h7FFFFFFF, 32'hFFC00000, 10'd5, 32'h00000000}, // R6, R8, R9
    '{1'b1, 10'd8,   32'h80000000, 32'h7FFFFFFF, 32'hFFC00000, 10'd8, 32'h7FC00000}, // R5
    '{1'b1, 10'h102, 32'hFFFFFFFF, 32'h7FFFFFFF, 32'hFFC00000, 10'd2, 32'h800000E0}  // R9 high index
  };

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic rd(input logic [9:0] w, input string what, input logic [31:0] exp);
    bus_we   = 1'b0;
    bus_addr = {w, 2'b00};
    #1;
    chk(what, bus_rdata, exp);
  endtask

  initial begin
    #(20 * 10000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    repeat (3) @(posedge clk);
    #2;
    chk("R10 irq during reset", irq_o, 32'h0);
    rd(10'd1, "R10 raw during reset", 32'h0);
    rd(10'd2, "R10 mask during reset", 32'h0);
    rd(10'd8, "R10 routing during reset", 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      src_i     = VEC[k].src;
      bus_we    = VEC[k].we;
      bus_addr  = {VEC[k].word, 2'b00};
      bus_wdata = VEC[k].wdata;
      @(posedge clk);
      #2;
      chk($sformatf("vector %0d irq_o (R6 R7 R8 R11)", k), irq_o, VEC[k].irq);
      rd(VEC[k].rdw, $sformatf("vector %0d rdata (R1 R2 R3 R4 R5 R9)", k), VEC[k].rd);
    end

    // R10: asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R10 async reset irq", irq_o, 32'h0);
    rd(10'd2, "R10 async reset mask", 32'h0);
    rd(10'd8, "R10 async reset routing", 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #2;
    chk("R10 R11 irq after release", irq_o, 32'h0);
    rd(10'd1, "R1 raw after release", 32'h7FFFFFFF);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule